// File: doc/BRIEF.md
# Line Frame Timebase with Start-Up Phase Alignment

This block produces the frame timing for one transmit line channel. Once it is running, it counts bit clocks through a frame whose nominal length comes from a host-programmed value, and it restarts at position zero when the frame ends. A divide-by-48 prescaler, restarted at every frame boundary, marks block boundaries inside the frame. At each frame end the block compares the measured FIFO fill against the watermark setting and decides whether the next frame carries two stuff bits.

After reset or a FIFO reset command, the block holds itself idle and waits for a PCM-side sync pulse. After that pulse it counts out a delay equal to the watermark setting, and then frame 0 begins. From then on the phase is free-running: further PCM sync pulses have no effect until another FIFO reset. The nominal frame period is 6 ms of bit clocks, and software sets it through the frame length input.

Top module: `frame_timebase`

## Requirements
- R1: During reset and while not aligned, `aligned`, `frameStart`, `blockTick`, `stuffNow` and `stuffSlot` are 0 and `bitPos` is 0.
- R2: When `pcmSync` is sampled high while the block is waiting, the first `frameStart` is seen exactly 1 + `wmLevel` clock cycles later. With `wmLevel` = 0 this is the very next cycle.
- R3: In an unstuffed frame, `bitPos` steps by one each cycle from 0 to `frameLen`-1, and the frame then restarts at 0, so the frame period is `frameLen` cycles.
- R4: `frameStart` is a one-cycle pulse and occurs only at `bitPos` 0. `frameLen` must be at least 2.
- R5: In the last cycle of each frame, the block sets the stuff decision for the next frame: stuffed if `fifoLevel` < `wmLevel`, and unstuffed otherwise, including the case where they are equal. `stuffNow` holds that decision for the whole frame and is 0 in frame 0.
- R6: A stuffed frame lasts `frameLen`+2 cycles. `stuffSlot` is high exactly at `bitPos` `frameLen` and `frameLen`+1.
- R7: `blockTick` is high at every `bitPos` that is a multiple of 48, counting from 0. `blockIdx` gives the number of the block within the frame, so it is 2 at `bitPos` 96.
- R8: `pcmSync` pulses that arrive while the block is aligned do not change the frame phase.
- R9: A `fifoRst` pulse makes the block unaligned from the next cycle, clears the stuff decision, and returns the block to waiting for a sync. A `pcmSync` that arrives in the same cycle as `fifoRst` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcmSync | input | 1 | 6 ms sync pulse from the PCM side |
| fifoRst | input | 1 | FIFO reset command; restarts alignment |
| frameLen | input | LEN_W | Nominal frame length in bit clocks |
| wmLevel | input | WM_W | FIFO watermark: start-up delay and stuffing threshold |
| fifoLevel | input | WM_W | Measured FIFO fill |
| aligned | output | 1 | Timebase is running |
| frameStart | output | 1 | Pulse at position 0 of each frame |
| bitPos | output | LEN_W+1 | Bit position within the frame |
| blockTick | output | 1 | Strobe at each 48-bit block boundary |
| blockIdx | output | BLK_W | Block number within the frame |
| stuffNow | output | 1 | The current frame is stuffed |
| stuffSlot | output | 1 | High during the two stuff bit positions |

## Verification
Some properties are checked on every cycle: the idle outputs while unaligned, the single-step advance of the position, the one-cycle width of the frame pulse, the stuff decision held constant inside a frame, block ticks falling on the 48-bit grid, stuff slots appearing only in stuffed frames past the nominal length, and the loss of alignment right after a FIFO reset. Other behaviours need a stimulus history, so only the directed scenarios can show them. These are the exact delay from sync to the first frame for several watermark values, the measured frame periods with and without stuffing, the strict less-than threshold, the phase staying put when a late sync arrives, and a sync being ignored when it comes in the same cycle as a reset.

// File: rtl/frame_timebase_pkg.sv
package frame_timebase_pkg;

  typedef enum logic [1:0] {
    TB_WAIT  = 2'd0,
    TB_DELAY = 2'd1,
    TB_RUN   = 2'd2
  } tbState_t;

  typedef struct packed {
    logic runEn;
    logic flush;
  } tbStrobe_t;

endpackage

// File: rtl/frame_timebase_ctrl.sv
module frame_timebase_ctrl
  import frame_timebase_pkg::*;
#(
  parameter int WM_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pcmSync,
  input  logic            fifoRst,
  input  logic [WM_W-1:0] wmLevel,
  output tbStrobe_t       strobes
);

  tbState_t        state;
  logic [WM_W-1:0] dlyCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= TB_WAIT;
      dlyCnt <= '0;
    end else if (fifoRst) begin
      state  <= TB_WAIT;
      dlyCnt <= '0;
    end else begin
      unique case (state)
        TB_WAIT: begin
          if (pcmSync) begin
            if (wmLevel == '0) begin
              state <= TB_RUN;
            end else begin
              state  <= TB_DELAY;
              dlyCnt <= wmLevel;
            end
          end
        end
        TB_DELAY: begin
          if (dlyCnt == WM_W'(1)) begin
            state  <= TB_RUN;
            dlyCnt <= '0;
          end else begin
            dlyCnt <= dlyCnt - WM_W'(1);
          end
        end
        TB_RUN:  state <= TB_RUN;
        default: state <= TB_WAIT;
      endcase
    end
  end

  always_comb begin
    strobes.runEn = (state == TB_RUN);
    strobes.flush = fifoRst;
  end

endmodule

// File: rtl/frame_timebase_dp.sv
module frame_timebase_dp
  import frame_timebase_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int WM_W     = 8,
  parameter int PRESCALE = 48,
  parameter int BLK_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        strobes,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [WM_W-1:0]  wmLevel,
  input  logic [WM_W-1:0]  fifoLevel,
  output logic             frameStart,
  output logic [LEN_W:0]   bitPos,
  output logic             blockTick,
  output logic [BLK_W-1:0] blockIdx,
  output logic             stuffNow,
  output logic             stuffSlot
);

  localparam int POS_W = LEN_W + 1;
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [POS_W-1:0] posCnt;
  logic [PRE_W-1:0] preCnt;
  logic [BLK_W-1:0] blkCnt;
  logic             stuffCur;
  logic [POS_W-1:0] nomLen;
  logic [POS_W-1:0] lastIdx;
  logic             frameEnd;
  logic             preWrap;

  always_comb begin
    nomLen   = {1'b0, frameLen};
    lastIdx  = nomLen - POS_W'(1) + (stuffCur ? POS_W'(2) : POS_W'(0));
    frameEnd = strobes.runEn && (posCnt == lastIdx);
    preWrap  = (preCnt == PRE_W'(PRESCALE - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush || !strobes.runEn) begin
      posCnt   <= '0;
      preCnt   <= '0;
      blkCnt   <= '0;
      stuffCur <= 1'b0;
    end else if (frameEnd) begin
      posCnt   <= '0;
      preCnt   <= '0;
      blkCnt   <= '0;
      stuffCur <= (fifoLevel < wmLevel);
    end else begin
      posCnt <= posCnt + POS_W'(1);
      if (preWrap) begin
        preCnt <= '0;
        blkCnt <= blkCnt + BLK_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  always_comb begin
    frameStart = strobes.runEn && (posCnt == '0);
    blockTick  = strobes.runEn && (preCnt == '0);
    bitPos     = posCnt;
    blockIdx   = blkCnt;
    stuffNow   = stuffCur;
    stuffSlot  = strobes.runEn && stuffCur && (posCnt >= nomLen);
  end

endmodule

// File: rtl/frame_timebase.sv
module frame_timebase
  import frame_timebase_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int WM_W     = 8,
  parameter int PRESCALE = 48,
  parameter int BLK_W    = $clog2((2 ** (LEN_W + 1)) / PRESCALE + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pcmSync,
  input  logic             fifoRst,
  input  logic [LEN_W-1:0] frameLen,
  input  logic [WM_W-1:0]  wmLevel,
  input  logic [WM_W-1:0]  fifoLevel,
  output logic             aligned,
  output logic             frameStart,
  output logic [LEN_W:0]   bitPos,
  output logic             blockTick,
  output logic [BLK_W-1:0] blockIdx,
  output logic             stuffNow,
  output logic             stuffSlot
);

  tbStrobe_t strobes;

  frame_timebase_ctrl #(.WM_W(WM_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pcmSync (pcmSync),
    .fifoRst (fifoRst),
    .wmLevel (wmLevel),
    .strobes (strobes)
  );

  frame_timebase_dp #(
    .LEN_W    (LEN_W),
    .WM_W     (WM_W),
    .PRESCALE (PRESCALE),
    .BLK_W    (BLK_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .frameLen   (frameLen),
    .wmLevel    (wmLevel),
    .fifoLevel  (fifoLevel),
    .frameStart (frameStart),
    .bitPos     (bitPos),
    .blockTick  (blockTick),
    .blockIdx   (blockIdx),
    .stuffNow   (stuffNow),
    .stuffSlot  (stuffSlot)
  );

  assign aligned = strobes.runEn;

endmodule

// File: rtl/frame_timebase_chk.sv
module frame_timebase_chk #(
  parameter int LEN_W    = 16,
  parameter int PRESCALE = 48
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoRst,
  input logic [LEN_W-1:0] frameLen,
  input logic             aligned,
  input logic             frameStart,
  input logic [LEN_W:0]   bitPos,
  input logic             blockTick,
  input logic             stuffNow,
  input logic             stuffSlot
);

  localparam int POS_W = LEN_W + 1;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |-> (bitPos == '0 && !frameStart && !blockTick && !stuffNow && !stuffSlot));

  p_pos_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (aligned && !frameStart) |-> (bitPos == $past(bitPos) + POS_W'(1)));

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  p_stuff_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (aligned && !frameStart) |-> $stable(stuffNow));

  p_slot_place_r6: assert property (@(posedge clk) disable iff (!rstN)
    stuffSlot |-> (stuffNow && bitPos >= {1'b0, frameLen}));

  p_pos_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    aligned |-> (bitPos <= {1'b0, frameLen} + POS_W'(1)));

  p_tick_grid_r7: assert property (@(posedge clk) disable iff (!rstN)
    blockTick |-> ((bitPos % POS_W'(PRESCALE)) == '0));

  p_flush_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoRst |=> !aligned);

endmodule

bind frame_timebase frame_timebase_chk #(.LEN_W(LEN_W), .PRESCALE(PRESCALE)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fifoRst    (fifoRst),
  .frameLen   (frameLen),
  .aligned    (aligned),
  .frameStart (frameStart),
  .bitPos     (bitPos),
  .blockTick  (blockTick),
  .stuffNow   (stuffNow),
  .stuffSlot  (stuffSlot)
);

// File: tb/test_frame_timebase.sv
module test_frame_timebase;

  localparam int LEN_W = 16;
  localparam int WM_W  = 8;
  localparam int BLK_W = $clog2((2 ** (LEN_W + 1)) / 48 + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             pcmSync = 1'b0;
  logic             fifoRst = 1'b0;
  logic [LEN_W-1:0] frameLen = 16'd10;
  logic [WM_W-1:0]  wmLevel = 8'd3;
  logic [WM_W-1:0]  fifoLevel = 8'd200;
  logic             aligned;
  logic             frameStart;
  logic [LEN_W:0]   bitPos;
  logic             blockTick;
  logic [BLK_W-1:0] blockIdx;
  logic             stuffNow;
  logic             stuffSlot;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frame_timebase i_frame_timebase (
    .clk(clk), .rstN(rstN), .pcmSync(pcmSync), .fifoRst(fifoRst),
    .frameLen(frameLen), .wmLevel(wmLevel), .fifoLevel(fifoLevel),
    .aligned(aligned), .frameStart(frameStart), .bitPos(bitPos),
    .blockTick(blockTick), .blockIdx(blockIdx), .stuffNow(stuffNow),
    .stuffSlot(stuffSlot)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseRst();
    fifoRst = 1'b1;
    step();
    fifoRst = 1'b0;
  endtask

  // Sync pulse, then count cycles until the first frame start.
  task automatic alignTo(input int wm, input string req);
    int n;
    wmLevel = WM_W'(wm);
    pulseRst();
    step();
    pcmSync = 1'b1;
    step();
    pcmSync = 1'b0;
    n = 1;
    while (!frameStart && n < 1000) begin
      step();
      n++;
    end
    check(n == 1 + wm, req, n, 1 + wm);
  endtask

  // Called at a frame start; returns the cycles until the next one.
  task automatic measureFrame(output int len, output int slots, output int badSlot);
    len = 0; slots = 0; badSlot = 0;
    do begin
      if (stuffSlot) begin
        slots++;
        if (bitPos < {1'b0, frameLen}) badSlot++;
      end
      step();
      len++;
    end while (!frameStart && len < 2000);
  endtask

  task automatic testReset();
    check(!aligned && !frameStart && bitPos == 0 && !stuffNow && !stuffSlot && !blockTick,
          "R1 reset idle", int'(aligned), 0);
  endtask

  task automatic testAlign();
    alignTo(3, "R2 align wm=3");
    alignTo(0, "R2 align wm=0");
    alignTo(7, "R2 align wm=7");
  endtask

  task automatic testPeriod();
    int len, sl, bad;
    int badPos;
    fifoLevel = 8'd200;
    alignTo(3, "R2 align before period");
    check(stuffNow == 1'b0, "R5 frame 0 unstuffed", int'(stuffNow), 0);
    badPos = 0;
    for (int i = 0; i < 10; i++) begin
      if (bitPos != i) badPos++;
      if (i > 0 && frameStart) badPos++;
      step();
    end
    check(badPos == 0, "R3 position sequence", badPos, 0);
    check(frameStart == 1'b1, "R4 start at wrap", int'(frameStart), 1);
    measureFrame(len, sl, bad);
    check(len == 10, "R3 unstuffed period", len, 10);
    check(sl == 0, "R6 no slots unstuffed", sl, 0);
  endtask

  task automatic testStuff();
    int len, sl, bad;
    // at a frame start (frame A): level below watermark
    fifoLevel = 8'd1;
    measureFrame(len, sl, bad);
    check(len == 10, "R5 decision applies to next frame", len, 10);
    check(stuffNow == 1'b1, "R5 stuffed after low fill", int'(stuffNow), 1);
    fifoLevel = 8'd3; // equal to watermark: not below
    measureFrame(len, sl, bad);
    check(len == 12, "R6 stuffed period", len, 12);
    check(sl == 2 && bad == 0, "R6 stuff slots", sl, 2);
    check(stuffNow == 1'b0, "R5 equal fill unstuffed", int'(stuffNow), 0);
    measureFrame(len, sl, bad);
    check(len == 10, "R5 period back to nominal", len, 10);
  endtask

  task automatic testLateSync();
    int len, sl, bad;
    fifoLevel = 8'd200;
    step(); step(); step();
    pcmSync = 1'b1;
    step();
    pcmSync = 1'b0;
    len = 4;
    while (!frameStart && len < 100) begin
      step();
      len++;
    end
    check(len == 10, "R8 late sync ignored", len, 10);
    check(aligned == 1'b1, "R8 still aligned", int'(aligned), 1);
  endtask

  task automatic testFlush();
    int starts;
    fifoLevel = 8'd1;
    measureFrame(starts, starts, starts); // next frame becomes stuffed
    check(stuffNow == 1'b1, "R9 stuffed before flush", int'(stuffNow), 1);
    step(); step();
    pulseRst();
    check(!aligned && bitPos == 0 && !stuffNow, "R9 flush clears", int'(aligned), 0);
    fifoRst = 1'b1;
    pcmSync = 1'b1;
    step();
    fifoRst = 1'b0;
    pcmSync = 1'b0;
    starts = 0;
    for (int i = 0; i < 30; i++) begin
      if (frameStart || aligned) starts++;
      step();
    end
    check(starts == 0, "R9 sync with flush ignored", starts, 0);
    fifoLevel = 8'd200;
  endtask

  task automatic testBlocks();
    int ticks, badTick, idxAt96;
    pulseRst();
    frameLen = 16'd100;
    alignTo(2, "R2 align long frame");
    ticks = 0; badTick = 0; idxAt96 = -1;
    for (int i = 0; i < 100; i++) begin
      if (blockTick) begin
        ticks++;
        if (i % 48 != 0) badTick++;
      end
      if (i == 96) idxAt96 = int'(blockIdx);
      step();
    end
    check(ticks == 3 && badTick == 0, "R7 block ticks", ticks, 3);
    check(idxAt96 == 2, "R7 block index", idxAt96, 2);
    check(frameStart == 1'b1, "R3 long frame period", int'(frameStart), 1);
  endtask

  initial begin
    repeat (4) step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testAlign();
    testPeriod();
    testStuff();
    testLateSync();
    testFlush();
    testBlocks();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule